// File: doc/BRIEF.md
# Priority Input Clock Selector

This block decides which of four candidate input clocks drives a synthesis loop. It does not switch the clocks. It produces the index of the chosen input, and the clock multiplexer and the loop use that index. Alarm detection is outside the block. Each input comes with a loss-of-signal flag, and an input counts as usable only while its flag is low.

**Manual mode.** The index comes from one of two sources:
- a set of select pins, when pin control is configured;
- a host selection register, when pin control is not configured.

**Automatic mode.** The block reads a programmable priority list and picks the best usable input. It fails over when the current input is lost. A revert option decides whether the block returns to a better input once that input recovers, or stays where it is.

A flag shows whether the chosen input is currently usable. A one-cycle strobe marks every change of the index.

Top module: `clk_input_selector`

## Requirements
- R1: In reset, `sel_idx` and the host selection register take the value of parameter DEFAULT_SEL (default 0), and `switch_pulse` is 0.
- R2: When `auto_mode`=0 and `pin_ctrl_en`=1, `sel_idx` takes the value on `sel_pins` at the next clock edge, whatever the alarms.
- R3: When `pin_ctrl_en`=1, host writes (`host_wr_en`=1) do not change the host selection register. This can be seen later, after pin control is turned off.
- R4: When `auto_mode`=0 and `pin_ctrl_en`=0, a write presented at edge k loads the host register. `sel_idx` shows the written value after edge k+1.
- R5: `sel_valid` is 1 exactly when `los[sel_idx]` is 0. Bit i of `los` is the alarm of input i, and 1 means the input is lost.
- R6: In automatic mode, the priority list `prio_list` holds four 2-bit input indices. Slot s sits at bits [2s+1:2s], and slot 0 is the highest priority. When the current input is lost, the next `sel_idx` is the input named by the lowest-numbered slot whose input has no alarm.
- R7: In automatic mode, when the selected input raises its alarm, the selector moves to the best-ranked input that is still usable. This happens one edge later.
- R8: In automatic mode with `revert_en`=1, the selector moves to the best-ranked usable input whenever it differs from the current one, even if the current input is still usable.
- R9: In automatic mode with `revert_en`=0, the selector keeps the current input for as long as that input stays usable.
- R10: In automatic mode, when every input has its alarm raised, `sel_idx` holds its value and `sel_valid` is 0.
- R11: `switch_pulse` is 1 for exactly the one cycle in which `sel_idx` shows a new value, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_mode | input | 1 | 1 selects automatic mode, 0 selects manual mode |
| pin_ctrl_en | input | 1 | 1 routes the manual selection from the pins and blocks host writes |
| sel_pins | input | 2 | Manual select pins |
| host_wr_en | input | 1 | Host write strobe for the selection register |
| host_wr_sel | input | 2 | Host write data |
| revert_en | input | 1 | 1 selects revert behaviour in automatic mode |
| prio_list | input | 8 | Four 2-bit input indices, slot 0 highest priority |
| los | input | 4 | Loss-of-signal alarm per input |
| sel_idx | output | 2 | Selected input index |
| sel_valid | output | 1 | Selected input currently has no alarm |
| switch_pulse | output | 1 | One-cycle strobe on each change of sel_idx |

## Verification
The hardest behaviour to reach is the automatic-mode decision between holding and moving. It depends on:
- which input is currently held;
- the ranking given by the priority list;
- the revert setting;
- the alarm pattern seen in the same cycle.

A single directed test only reaches a handful of these combinations. The stimulus therefore steps through every ordering of the four inputs in the priority list, under both revert settings. For each ordering, it walks an alarm sequence that visits all sixteen patterns twice in a scrambled order. This leaves the selector on many different inputs when each new pattern arrives, including the all-alarm pattern. A model in the bench predicts each edge from the ranking rules.

// File: rtl/clk_input_selector.sv
module clk_input_selector #(
  parameter int N_IN        = 4,
  parameter int DEFAULT_SEL = 0,
  localparam int IDX_W      = $clog2(N_IN)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   auto_mode,
  input  logic                   pin_ctrl_en,
  input  logic [IDX_W-1:0]       sel_pins,
  input  logic                   host_wr_en,
  input  logic [IDX_W-1:0]       host_wr_sel,
  input  logic                   revert_en,
  input  logic [N_IN*IDX_W-1:0]  prio_list,
  input  logic [N_IN-1:0]        los,
  output logic [IDX_W-1:0]       sel_idx,
  output logic                   sel_valid,
  output logic                   switch_pulse
);

  logic [IDX_W-1:0] sel_q, host_q, best, nxt;
  logic             found;

  always_comb begin
    best  = sel_q;
    found = 1'b0;
    for (int s = N_IN-1; s >= 0; s--) begin
      if (!los[prio_list[s*IDX_W +: IDX_W]]) begin
        best  = prio_list[s*IDX_W +: IDX_W];
        found = 1'b1;
      end
    end
  end

  always_comb begin
    if (!auto_mode)                nxt = pin_ctrl_en ? sel_pins : host_q;
    else if (!found)               nxt = sel_q;
    else if (los[sel_q] || revert_en) nxt = best;
    else                           nxt = sel_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q        <= IDX_W'(DEFAULT_SEL);
      host_q       <= IDX_W'(DEFAULT_SEL);
      switch_pulse <= 1'b0;
    end else begin
      sel_q        <= nxt;
      switch_pulse <= (nxt != sel_q);
      if (host_wr_en && !pin_ctrl_en) host_q <= host_wr_sel;
    end
  end

  assign sel_idx   = sel_q;
  assign sel_valid = ~los[sel_q];

  AST_PIN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_mode && pin_ctrl_en) |=> (sel_idx == $past(sel_pins))); // R2

  AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ctrl_en |=> $stable(host_q)); // R3

  AST_NONREVERT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && !revert_en && !los[sel_idx]) |=> $stable(sel_idx)); // R9

  AST_ALL_LOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && (&los)) |=> $stable(sel_idx)); // R10

  AST_PULSE_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_idx != $past(sel_idx)) |-> switch_pulse); // R11

  AST_PULSE_ONLY_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> (sel_idx != $past(sel_idx))); // R11

endmodule

// File: tb/clk_input_selector_tb.sv
`timescale 1ns/1ps
module clk_input_selector_tb;
  logic clk = 0, rst_n = 0;
  logic auto_mode = 0, pin_ctrl_en = 0, host_wr_en = 0, revert_en = 0;
  logic [1:0] sel_pins = 0, host_wr_sel = 0;
  logic [7:0] prio_list = 8'hE4;
  logic [3:0] los = 0;
  logic [1:0] sel_idx;
  logic sel_valid, switch_pulse;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [1:0] exp_sel = 0, exp_host = 0;
  string step_tag;

  always #2.5 clk = ~clk;

  clk_input_selector u_dut (
    .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .pin_ctrl_en(pin_ctrl_en),
    .sel_pins(sel_pins), .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel),
    .revert_en(revert_en), .prio_list(prio_list), .los(los),
    .sel_idx(sel_idx), .sel_valid(sel_valid), .switch_pulse(switch_pulse));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] predict();
    int first = -1;
    logic [1:0] cand;
    if (!auto_mode) begin
      step_tag = pin_ctrl_en ? "R2" : "R4";
      return pin_ctrl_en ? sel_pins : exp_host;
    end
    for (int s = 0; s < 4; s++) begin
      cand = prio_list[2*s +: 2];
      if (first < 0 && !los[cand]) first = cand;
    end
    if (first < 0) begin step_tag = "R10"; return exp_sel; end
    if (los[exp_sel]) begin step_tag = "R7 R6"; return 2'(first); end
    if (revert_en) begin step_tag = "R8"; return 2'(first); end
    step_tag = "R9";
    return exp_sel;
  endfunction

  task automatic step();
    logic [1:0] nxt = predict();
    bit moved = (nxt != exp_sel);
    exp_sel = nxt;
    if (host_wr_en && !pin_ctrl_en) exp_host = host_wr_sel;
    @(posedge clk);
    @(negedge clk);
    check(step_tag, sel_idx, exp_sel);
    check("R5", sel_valid, !los[exp_sel]);
    check("R11", switch_pulse, moved);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", sel_idx, 0);
    check("R1", switch_pulse, 0);
    rst_n = 1;
    los = 4'b0001;
    step();

    // R2: pin-driven manual selection, alarms ignored
    pin_ctrl_en = 1;
    for (int p = 0; p < 4; p++) begin
      sel_pins = 2'(3 - p);
      los = 4'(1 << (3 - p));
      step();
    end
    // R3: host writes blocked under pin control
    host_wr_en = 1; host_wr_sel = 2'd2; step();
    host_wr_en = 0; pin_ctrl_en = 0; los = 0; step();
    step();
    check("R3", sel_idx, 0);

    // R4: host register path over all values
    for (int h = 0; h < 4; h++) begin
      host_wr_en = 1; host_wr_sel = 2'(h ^ 1); step();
      host_wr_en = 0; step();
      check("R4", sel_idx, h ^ 1);
    end

    // R6..R10: all priority orderings, both revert settings, alarm walks
    auto_mode = 1;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++) begin
            if (a == b || a == c || a == d || b == c || b == d || c == d) continue;
            for (int r = 0; r < 2; r++) begin
              prio_list = {2'(d), 2'(c), 2'(b), 2'(a)};
              revert_en = r[0];
              for (int j = 0; j < 32; j++) begin
                los = 4'((j * 5 + 3 + a) % 16);
                step();
              end
            end
          end

    // R10: all lost, hold
    los = 4'hF;
    step(); step();
    check("R10", sel_valid, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule